// File: doc/BRIEF.md
# Trimmed Seconds Prescaler

This block turns a 32.768 kHz clock into a seconds count. A 16-bit prescaler runs for 32768 input clocks per second. Each overflow advances a seconds counter that runs from 0 to 59.

A 16-bit trim word corrects a slow or fast crystal. Every 20 or 60 seconds, the prescaler period that closes the chosen second is made longer or shorter by an even number of clocks. Bit 15 of the trim word chooses the interval. Bit 12 is the sign of the correction. Bits 11..0 hold a coded magnitude.

Software writes the whole word in one access. The write is refused while the seconds count sits on a value where a correction could be pending. The prescaler length is fixed when each period starts, so a write that arrives during a period changes only later periods.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: After reset the seconds output is 0, the reject flag is low and the trim word is 0x0000, which gives no correction.
- R2: With no correction pending, each prescaler period lasts 2^(CNT_W-1) input clocks (32768 by default), and its overflow advances the seconds output by one.
- R3: The seconds output counts 0,1,…,59 and then wraps to 0. It never leaves that range, and it changes only on a prescaler overflow.
- R4: With trim bit 15 = 0, a non-null correction applies to the periods that run while the seconds output is 19, 39 or 59. These are the periods whose overflow lands on second 0, 20 or 40. All other periods are nominal.
- R5: With trim bit 15 = 1, the correction applies only to the period that runs while the seconds output is 59. The periods at 19 and 39 stay nominal.
- R6: With trim bit 12 = 0 and magnitude M = bits 11..0, where M ≥ 2, the corrected period is longer by (M−1)×2 clocks.
- R7: With trim bit 12 = 1 and M ≠ 0xFFF, the corrected period is shorter by ((~M & 0xFFF)+1)×2 clocks.
- R8: Three codes give no correction: bit 12 = 0 with M = 0 or M = 1, and bit 12 = 1 with M = 0xFFF. Bits 14..13 have no effect.
- R9: A write while the seconds output is 0, 20 or 40 leaves the trim word unchanged and raises the reject flag for the one cycle after the write. Any other write loads the word and keeps the flag low.
- R10: The length of a period is taken from the trim word as it stood at the overflow that starts the period. A write accepted in the same cycle as that overflow affects only later periods.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_32k | input | 1 | 32.768 kHz counting clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trim_wr | input | 1 | Write strobe for the trim word |
| trim_wdata | input | 16 | Trim word: bit 15 interval select, bit 12 sign, bits 11..0 magnitude |
| trim_rej | output | 1 | High for one cycle after a refused write |
| sec_o | output | 6 | Current seconds count, 0 to 59 |

## Verification
Two events can fall in the same clock edge: a trim write and the prescaler overflow that latches the next period's length. The bench creates this case by counting clocks from the start of second 38 and asserting the strobe on exactly the overflow edge into 39. The accepted word must not shorten or lengthen the period for 39, and must take effect at 59. A second case is also covered: writes landing just after an overflow into 0, 20 or 40 must be refused. This is judged by the reject pulse and by the lengths of the periods that follow.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  localparam int MAG_W    = 12;
  localparam int WORD_W   = 16;
  localparam int SEC_W    = 6;
  localparam int SEC_LAST = 59;
  localparam int SLOT     = 20;
  localparam int DLT_W    = MAG_W + 3;

  // Stored trim state: interval select, sign, magnitude.
  typedef struct packed {
    logic             dev;
    logic             shrink;
    logic [MAG_W-1:0] mag;
  } trim_t;

  // Signed clock offset encoded by a trim word (null codes give zero).
  function automatic logic signed [DLT_W-1:0] trim_delta(input trim_t t);
    logic [MAG_W:0]   steps;
    logic [MAG_W+1:0] amt;
    steps = '0;
    if (!t.shrink) begin
      if (t.mag > MAG_W'(1)) steps = {1'b0, t.mag} - (MAG_W+1)'(1);
    end else if (t.mag != '1) begin
      steps = {1'b0, ~t.mag} + (MAG_W+1)'(1);
    end
    amt = {steps, 1'b0};
    trim_delta = t.shrink ? -$signed({1'b0, amt}) : $signed({1'b0, amt});
  endfunction

endpackage

// File: rtl/rtc_trim_reg.sv
module rtc_trim_reg
  import rtc_trim_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_data,
  input  logic [SEC_W-1:0]        sec,
  output trim_t                   trim_q,
  output logic                    rej_q
);

  trim_t trim_d;
  logic  rej_d;
  logic  blocked;
  logic  unused_rsvd;

  assign unused_rsvd = ^wr_data[14:13];

  always_comb begin
    blocked = (sec == SEC_W'(0)) || (sec == SEC_W'(SLOT)) ||
              (sec == SEC_W'(2*SLOT));
    trim_d  = trim_q;
    rej_d   = 1'b0;
    if (wr_en) begin
      if (blocked) begin
        rej_d = 1'b1;
      end else begin
        trim_d.dev    = wr_data[15];
        trim_d.shrink = wr_data[12];
        trim_d.mag    = wr_data[MAG_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= '0;
      rej_q  <= 1'b0;
    end else begin
      trim_q <= trim_d;
      rej_q  <= rej_d;
    end
  end

endmodule

// File: rtl/rtc_trim_tc.sv
module rtc_trim_tc
  import rtc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  trim_t                trim,
  input  logic [SEC_W-1:0]     sec_nxt,
  output logic [CNT_W-1:0]     tc_nxt
);

  localparam int NOM_TC = (1 << (CNT_W-1)) - 1;

  logic                    hit;
  logic signed [DLT_W-1:0] delta;
  int                      sum;

  always_comb begin
    if (trim.dev) begin
      hit = (sec_nxt == SEC_W'(SEC_LAST));
    end else begin
      hit = (sec_nxt == SEC_W'(SEC_LAST - 2*SLOT)) ||
            (sec_nxt == SEC_W'(SEC_LAST - SLOT)) ||
            (sec_nxt == SEC_W'(SEC_LAST));
    end
    delta  = trim_delta(trim);
    sum    = NOM_TC + (hit ? int'(delta) : 0);
    tc_nxt = CNT_W'(sum);
  end

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tc_nxt,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] tc_q,
  output logic             tick
);

  localparam logic [CNT_W-1:0] NOM_TC = CNT_W'((1 << (CNT_W-1)) - 1);

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] tc_d;

  always_comb begin
    tick  = (cnt_q == tc_q);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
    tc_d  = tick ? tc_nxt : tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tc_q  <= NOM_TC;
    end else begin
      cnt_q <= cnt_d;
      tc_q  <= tc_d;
    end
  end

endmodule

// File: rtl/rtc_sec_cnt.sv
module rtc_sec_cnt
  import rtc_trim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [SEC_W-1:0] sec_q,
  output logic [SEC_W-1:0] sec_nxt
);

  always_comb begin
    sec_nxt = (sec_q == SEC_W'(SEC_LAST)) ? '0 : sec_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
    end else if (tick) begin
      sec_q <= sec_nxt;
    end
  end

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk_32k,
  input  logic        rst_n,
  input  logic        trim_wr,
  input  logic [15:0] trim_wdata,
  output logic        trim_rej,
  output logic [5:0]  sec_o
);

  logic [1:0]       rst_sync;
  logic             rst_s;
  trim_t            trim_q;
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] sec_nxt;
  logic [CNT_W-1:0] tc_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tc_q;
  logic             tick;

  always_ff @(posedge clk_32k or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  rtc_trim_reg u_reg (
    .clk     (clk_32k),
    .rst_n   (rst_s),
    .wr_en   (trim_wr),
    .wr_data (trim_wdata),
    .sec     (sec_q),
    .trim_q  (trim_q),
    .rej_q   (trim_rej)
  );

  rtc_trim_tc #(.CNT_W(CNT_W)) u_tc (
    .trim    (trim_q),
    .sec_nxt (sec_nxt),
    .tc_nxt  (tc_nxt)
  );

  rtc_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk    (clk_32k),
    .rst_n  (rst_s),
    .tc_nxt (tc_nxt),
    .cnt_q  (cnt_q),
    .tc_q   (tc_q),
    .tick   (tick)
  );

  rtc_sec_cnt u_sec (
    .clk     (clk_32k),
    .rst_n   (rst_s),
    .tick    (tick),
    .sec_q   (sec_q),
    .sec_nxt (sec_nxt)
  );

  assign sec_o = sec_q;

endmodule

// File: rtl/rtc_trim_chk.sv
module rtc_trim_chk
  import rtc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_s,
  input logic             trim_wr,
  input logic [15:0]      trim_wdata,
  input logic             trim_rej,
  input logic [5:0]       sec_o,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc_q,
  input trim_t            trim_q
);

  localparam logic [CNT_W-1:0] NOM_TC = CNT_W'((1 << (CNT_W-1)) - 1);

  logic blk;
  assign blk = (sec_o == 6'd0) || (sec_o == 6'd20) || (sec_o == 6'd40);

  assert_sec_range_R3: assert property (@(posedge clk) disable iff (!rst_s)
    sec_o <= 6'd59);

  assert_sec_step_R3: assert property (@(posedge clk) disable iff (!rst_s)
    tick |=> sec_o == (($past(sec_o) == 6'd59) ? 6'd0 : 6'($past(sec_o) + 6'd1)));

  assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !tick |=> $stable(sec_o));

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_s)
    cnt <= tc_q);

  assert_tc_hold_R10: assert property (@(posedge clk) disable iff (!rst_s)
    !tick |=> $stable(tc_q));

  assert_nominal_R4: assert property (@(posedge clk) disable iff (!rst_s)
    tick |=> (sec_o == 6'd19 || sec_o == 6'd39 || sec_o == 6'd59 || tc_q == NOM_TC));

  assert_dev_sel_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (tick && trim_q.dev) |=> (sec_o == 6'd59 || tc_q == NOM_TC));

  assert_reject_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (trim_wr && blk) |=> (trim_rej && $stable(trim_q)));

  assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (trim_wr && !blk) |=> (!trim_rej &&
      trim_q == {$past(trim_wdata[15]), $past(trim_wdata[12]), $past(trim_wdata[11:0])}));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_s)
    !trim_wr |=> !trim_rej);

endmodule

bind rtc_trim_prescaler rtc_trim_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk_32k),
  .rst_s      (rst_s),
  .trim_wr    (trim_wr),
  .trim_wdata (trim_wdata),
  .trim_rej   (trim_rej),
  .sec_o      (sec_o),
  .tick       (tick),
  .cnt        (cnt_q),
  .tc_q       (tc_q),
  .trim_q     (trim_q)
);

// File: tb/rtc_trim_prescaler_tb.sv
module rtc_trim_prescaler_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int NOM_P      = 1 << (CNT_W-1);
  localparam int WD_CYCLES  = 190000;

  typedef struct {
    int    sec;
    int    len;
    string tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        trim_wr;
  logic [15:0] trim_wdata;
  logic        trim_rej;
  logic [5:0]  sec_o;

  exp_t        sb_q[$];
  int          total = 0;
  int          bad   = 0;
  int          drv_prev = 0;
  logic [15:0] model = 16'h0000;
  int          mon_prev = 0;
  int          mon_cyc = 0;
  int          mon_last = 0;
  bit          mon_started = 1'b0;
  bit          mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_trim_prescaler #(.CNT_W(CNT_W)) dut_i (
    .clk_32k    (clk),
    .rst_n      (rst_n),
    .trim_wr    (trim_wr),
    .trim_wdata (trim_wdata),
    .trim_rej   (trim_rej),
    .sec_o      (sec_o)
  );

  function automatic bit is_hit(logic [15:0] t, int s);
    return t[15] ? (s == 59) : (s == 19 || s == 39 || s == 59);
  endfunction

  function automatic int corr(logic [15:0] t, int s);
    int m;
    m = int'(t[11:0]);
    if (!is_hit(t, s)) return 0;
    if (!t[12]) return (m >= 2) ? (m - 1) * 2 : 0;
    return (m == 4095) ? 0 : -((4095 - m) + 1) * 2;
  endfunction

  function automatic string tag_of(logic [15:0] t, int s);
    if (corr(t, s) != 0) return {t[15] ? "R5/" : "R4/", t[12] ? "R7" : "R6"};
    if (is_hit(t, s)) return "R8";
    if (t[15] && (s == 19 || s == 39)) return "R5";
    return "R2";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int s, input string tag);
    exp_t e;
    e.sec = s;
    e.len = NOM_P + corr(model, s);
    e.tag = (tag == "") ? tag_of(model, s) : tag;
    sb_q.push_back(e);
  endtask

  task automatic next_sec();
    do @(negedge clk); while (int'(sec_o) == drv_prev);
    drv_prev = int'(sec_o);
    push(drv_prev, "");
  endtask

  task automatic run_to(input int s);
    while (drv_prev != s) next_sec();
  endtask

  task automatic do_write(input logic [15:0] d);
    bit blk;
    blk = (drv_prev == 0 || drv_prev == 20 || drv_prev == 40);
    trim_wr    = 1'b1;
    trim_wdata = d;
    @(negedge clk);
    trim_wr = 1'b0;
    chk(trim_rej == blk, "R9 flag after write", int'(trim_rej), int'(blk));
    @(negedge clk);
    chk(trim_rej == 1'b0, "R9 flag one cycle", int'(trim_rej), 0);
    if (!blk) model = d;
  endtask

  // Monitor: measures clocks between seconds changes and pops expectations.
  initial begin
    forever begin
      @(negedge clk);
      mon_cyc++;
      if (mon_on && int'(sec_o) != mon_prev) begin
        if (mon_started) begin
          chk(int'(sec_o) == ((mon_prev == 59) ? 0 : mon_prev + 1), "R3 step",
              int'(sec_o), (mon_prev == 59) ? 0 : mon_prev + 1);
          if (sb_q.size() > 0 && sb_q[0].sec == mon_prev) begin
            chk(mon_cyc - mon_last == sb_q[0].len, sb_q[0].tag,
                mon_cyc - mon_last, sb_q[0].len);
            void'(sb_q.pop_front());
          end
        end
        mon_started = 1'b1;
        mon_last    = mon_cyc;
        mon_prev    = int'(sec_o);
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got %0d cycles expected fewer", WD_CYCLES);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len38;
    rst_n      = 1'b0;
    trim_wr    = 1'b0;
    trim_wdata = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sec_o == 6'd0, "R1 seconds", int'(sec_o), 0);
    chk(trim_rej == 1'b0, "R1 reject flag", int'(trim_rej), 0);
    mon_prev = 0;
    mon_on   = 1'b1;

    // Phase A: default code gives nominal seconds, then lengthen every 20 s.
    run_to(1);
    repeat (3) @(negedge clk);
    do_write(16'h000B);
    run_to(20);
    repeat (3) @(negedge clk);
    do_write(16'h9FFB);          // refused at 20 (R9): sec 39 stays lengthened
    run_to(0);

    // Phase B: refused at 0, then shorten only at the minute (R5, R7).
    repeat (3) @(negedge clk);
    do_write(16'h0002);
    run_to(1);
    repeat (3) @(negedge clk);
    do_write(16'h9FFB);
    run_to(40);
    repeat (3) @(negedge clk);
    do_write(16'h000B);
    run_to(0);

    // Phase C: null codes (R8) and write on the overflow edge (R10).
    run_to(1);
    repeat (3) @(negedge clk);
    do_write(16'h1FFF);
    run_to(21);
    repeat (3) @(negedge clk);
    do_write(16'h6000);
    run_to(38);
    len38 = NOM_P + corr(model, 38);
    repeat (len38 - 1) @(negedge clk);
    trim_wr    = 1'b1;
    trim_wdata = 16'h0004;
    @(negedge clk);
    trim_wr = 1'b0;
    chk(sec_o == 6'd39, "R10 edge alignment", int'(sec_o), 39);
    chk(trim_rej == 1'b0, "R9 edge write accepted", int'(trim_rej), 0);
    drv_prev = int'(sec_o);
    push(drv_prev, "R10 old word kept");
    model = 16'h0004;
    @(negedge clk);
    chk(trim_rej == 1'b0, "R9 flag one cycle", int'(trim_rej), 0);
    run_to(0);
    repeat (3) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule